// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the chip last came out of reset. Four event inputs report a power-on, a brown-out, an external-pin and a watchdog reset. Each event sets a sticky flag that stays set until firmware clears it. One 8-bit register on a simple address/write-enable/data bus exposes the flags. Each flag has its own clearing rule. A power-on event wipes the watchdog and external flags. The power-on flag itself is only cleared by firmware writing a zero into its bit.

A reset-interrupt request output stays high while any flag is set. Because flags accumulate, firmware should read the register early after boot and then clear it. The next read will then show only the causes that have happened since. Writing a one to a flag bit does nothing, so firmware can clear one flag without disturbing the others.

Top module: `rstcause_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags clear. Afterwards the register reads 0x00 and `rst_irq` is low.
- R2: A read at offset 0x02B returns the watchdog flag in bit 3, the external flag in bit 1 and the power-on flag in bit 0. Bits 7..4 and bit 2 always read 0.
- R3: `bus_rdata` is 0x00 whenever `bus_addr` is not 0x02B. The read path is combinational.
- R4: A high `ev_wdt` at a clock edge sets bit 3 from that edge on.
- R5: A high `ev_ext` at a clock edge sets bit 1 from that edge on.
- R6: A high `ev_por` or `ev_bod` at a clock edge sets bit 0 from that edge on.
- R7: A high `ev_por` clears bits 3 and 1. A high `ev_bod` leaves bits 3 and 1 unchanged.
- R8: Bit 0 is cleared only by a write of 0 to bit 0 at offset 0x02B. No reset event clears it.
- R9: A write of 1 to a flag bit leaves that flag unchanged. Write data in bits 7..4 and bit 2 is ignored. Writes at any other address change nothing.
- R10: When a set event and a clear (a zero-write or a power-on clear) hit the same flag in the same cycle, the set wins and the flag is 1.
- R11: Flags are cumulative. A new event sets its own flag and leaves other uncleared flags set.
- R12: `rst_irq` is high exactly when at least one of bits 3, 1 and 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag storage |
| ev_por | input | 1 | Power-on reset event, sampled each edge |
| ev_bod | input | 1 | Brown-out reset event, sampled each edge |
| ev_ext | input | 1 | External-pin reset event, sampled each edge |
| ev_wdt | input | 1 | Watchdog reset event, sampled each edge |
| bus_addr | input | ADDR_W (12) | Register bus address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| rst_irq | output | 1 | Non-maskable reset-interrupt request |

## Verification
The assertions assume the event inputs and the bus are stable around the sampling edge. They also assume a write is a single-cycle strobe whose address and data are valid whenever `bus_we` is high. The bench meets this by changing every input only on the falling clock edge and holding each event or write for exactly one cycle. Coincident cases, such as an event together with a zero-write or a power-on together with an external event, are driven deliberately inside that one-cycle window to exercise the priority rules.

// File: rtl/rstcause_pkg.sv
// Package: shared constants for the reset-cause register.
// Assumes an 8-bit register. The flag bit positions are fixed because
// firmware decodes them.
package rstcause_pkg;
    localparam int REG_W = 8;
    localparam int POR_BIT = 0;
    localparam int EXT_BIT = 1;
    localparam int WDT_BIT = 3;
    // Bits that hold a flag; the other bits are reserved.
    localparam logic [REG_W-1:0] FLAG_MASK =
        (REG_W'(1) << POR_BIT) | (REG_W'(1) << EXT_BIT) | (REG_W'(1) << WDT_BIT);
    // Flags that a power-on event clears.
    localparam logic [REG_W-1:0] PORCLR_MASK =
        (REG_W'(1) << EXT_BIT) | (REG_W'(1) << WDT_BIT);
    // Flags that raise the reset interrupt.
    localparam logic [REG_W-1:0] IRQ_MASK = FLAG_MASK;

    typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/rstcause_flag.sv
// Module: one sticky reset-cause flag.
// Priority is set, then clear, then hold. CLR_ON_POR chooses whether a
// power-on event counts as a clear. Assumes all inputs are synchronous to clk.
module rstcause_flag #(
    parameter bit CLR_ON_POR = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic sw_clr_i,
    input  logic por_i,
    output logic q_o
);
    logic hw_clr;

    // Power-on clear is only present when the parameter asks for it.
    always_comb hw_clr = CLR_ON_POR ? por_i : 1'b0;

    // Flag storage: set beats any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                q_o <= 1'b0;
        else if (set_i)            q_o <= 1'b1;
        else if (sw_clr_i || hw_clr) q_o <= 1'b0;
    end
endmodule

// File: rtl/rstcause_decode.sv
// Module: address match and write decode for the reset-cause register.
// Produces a per-bit clear request for flag bits written with 0. Assumes a
// write is a one-cycle strobe on bus_we.
module rstcause_decode
    import rstcause_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(12'h02B)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  reg_t              wdata_i,
    output logic              hit_o,
    output reg_t              sw_clr_o
);
    // Address compare.
    always_comb hit_o = (addr_i == REG_ADDR);

    // Zero-write on a flag bit requests its clear; reserved bits never do.
    always_comb sw_clr_o = (hit_o && we_i) ? (~wdata_i & FLAG_MASK) : '0;
endmodule

// File: rtl/rstcause_rdmux.sv
// Module: combinational read path. Shows the flags at the register address
// and zero elsewhere. Assumes the flag vector already has zero in reserved
// bits.
module rstcause_rdmux
    import rstcause_pkg::*;
(
    input  logic hit_i,
    input  reg_t flags_i,
    output reg_t rdata_o
);
    // Select the register or zero.
    always_comb rdata_o = hit_i ? (flags_i & FLAG_MASK) : '0;
endmodule

// File: rtl/rstcause_reg.sv
// Module: reset-cause status register (top).
// Records power-on/brown-out, external and watchdog reset events in sticky
// flags and raises a reset interrupt while any flag is set. Assumes the event
// inputs are already synchronous one-cycle (or longer) indications.
module rstcause_reg
    import rstcause_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(12'h02B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_por,
    input  logic              ev_bod,
    input  logic              ev_ext,
    input  logic              ev_wdt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              rst_irq
);
    reg_t set_vec;
    reg_t sw_clr;
    reg_t flag_q;
    logic hit;

    // Route each event to the bit it sets.
    always_comb begin
        set_vec          = '0;
        set_vec[POR_BIT] = ev_por | ev_bod;
        set_vec[EXT_BIT] = ev_ext;
        set_vec[WDT_BIT] = ev_wdt;
    end

    rstcause_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_decode (
        .addr_i   (bus_addr),
        .we_i     (bus_we),
        .wdata_i  (bus_wdata),
        .hit_o    (hit),
        .sw_clr_o (sw_clr)
    );

    // One flag cell per flag bit; reserved bits are tied to zero.
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (FLAG_MASK[i]) begin : g_flag
            rstcause_flag #(.CLR_ON_POR(PORCLR_MASK[i])) u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (set_vec[i]),
                .sw_clr_i (sw_clr[i]),
                .por_i    (ev_por),
                .q_o      (flag_q[i])
            );
        end else begin : g_rsvd
            assign flag_q[i] = 1'b0;
        end
    end

    rstcause_rdmux u_rdmux (
        .hit_i   (hit),
        .flags_i (flag_q),
        .rdata_o (bus_rdata)
    );

    // Interrupt request while any interrupting flag is set.
    always_comb rst_irq = |(flag_q & IRQ_MASK);
endmodule

// File: rtl/rstcause_chk.sv
// Module: assertion checker for rstcause_reg, attached by bind.
// Assumes inputs change away from the rising edge.
module rstcause_chk #(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(12'h02B)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_por,
    input logic              ev_bod,
    input logic              ev_ext,
    input logic              ev_wdt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              rst_irq,
    input logic [7:0]        flag_q
);
    logic wr_hit;
    always_comb wr_hit = bus_we && (bus_addr == REG_ADDR);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (flag_q == 8'h00));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & 8'hF4) == 8'h00);

    p_other_addr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));

    p_wdt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt |=> flag_q[3]);

    p_ext_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ext |=> flag_q[1]);

    p_por_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_por || ev_bod) |=> flag_q[0]);

    p_por_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_por && !ev_ext) |=> !flag_q[1]);

    p_por_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !(wr_hit && !bus_wdata[0])) |=> flag_q[0]);

    p_write_one_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[1] && wr_hit && bus_wdata[1] && !ev_por) |=> flag_q[1]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt && wr_hit && !bus_wdata[3]) |=> flag_q[3]);

    p_irq_matches_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_ADDR) |-> (rst_irq == (bus_rdata != 8'h00)));
endmodule

bind rstcause_reg rstcause_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_por    (ev_por),
    .ev_bod    (ev_bod),
    .ev_ext    (ev_ext),
    .ev_wdt    (ev_wdt),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_irq   (rst_irq),
    .flag_q    (flag_q)
);

// File: tb/rstcause_reg_bench.sv
// Directed bench for rstcause_reg. Inputs change on the falling edge; a
// one-cycle stimulus takes effect at the next rising edge and is checked
// on the falling edge after it.
module rstcause_reg_bench;
    localparam logic [11:0] RA = 12'h02B;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_por, ev_bod, ev_ext, ev_wdt;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        rst_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rstcause_reg u_rstcause_reg (
        .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bod(ev_bod),
        .ev_ext(ev_ext), .ev_wdt(ev_wdt), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_irq(rst_irq)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // Read at an address (combinational) and compare value and irq.
    task automatic rd(input logic [11:0] a, input logic [7:0] exp, input logic irq_exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, req);
        check({7'd0, rst_irq}, {7'd0, irq_exp}, req);
        bus_addr = RA;
    endtask

    // One cycle of stimulus; ev = {wdt, ext, bod, por}.
    task automatic cyc(input logic [3:0] ev, input logic we, input logic [7:0] wd, input logic [11:0] a);
        @(negedge clk);
        {ev_wdt, ev_ext, ev_bod, ev_por} = ev;
        bus_we = we; bus_wdata = wd; bus_addr = a;
        @(negedge clk);
        {ev_wdt, ev_ext, ev_bod, ev_por} = 4'b0;
        bus_we = 1'b0; bus_wdata = 8'h00; bus_addr = RA;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        ev_wdt = 1'b1;  // event during reset must be overridden
        @(negedge clk); @(negedge clk);
        ev_wdt = 1'b0; rst_n = 1'b1;
        rd(RA, 8'h00, 1'b0, "R1 reset value");
    endtask

    task automatic t_wdt;
        cyc(4'b1000, 1'b0, 8'h00, RA);
        rd(RA, 8'h08, 1'b1, "R4 watchdog sets bit3 / R12 irq");
        cyc(4'b0000, 1'b1, 8'h00, RA);
        rd(RA, 8'h00, 1'b0, "R12 irq low after clear");
    endtask

    task automatic t_ext_bod;
        cyc(4'b0100, 1'b0, 8'h00, RA);
        rd(RA, 8'h02, 1'b1, "R5 external sets bit1");
        cyc(4'b0010, 1'b0, 8'h00, RA);
        rd(RA, 8'h03, 1'b1, "R6 brown-out sets bit0, R7 bod keeps bit1");
        cyc(4'b0000, 1'b1, 8'h00, RA);
        cyc(4'b0001, 1'b0, 8'h00, RA);
        rd(RA, 8'h01, 1'b1, "R6 power-on sets bit0");
    endtask

    task automatic t_cumulative_por;
        cyc(4'b1000, 1'b0, 8'h00, RA);
        cyc(4'b0100, 1'b0, 8'h00, RA);
        rd(RA, 8'h0B, 1'b1, "R11 cumulative / R2 layout and reserved zero");
        cyc(4'b0001, 1'b0, 8'h00, RA);
        rd(RA, 8'h01, 1'b1, "R7 power-on clears bits 3 and 1");
        cyc(4'b0001, 1'b0, 8'h00, RA);
        rd(RA, 8'h01, 1'b1, "R8 power-on does not clear bit0");
    endtask

    task automatic t_writes;
        cyc(4'b1100, 1'b0, 8'h00, RA);
        rd(RA, 8'h0B, 1'b1, "R11 all three flags");
        cyc(4'b0000, 1'b1, 8'hFF, RA);
        rd(RA, 8'h0B, 1'b1, "R9 writing ones keeps flags");
        cyc(4'b0000, 1'b1, 8'hFD, RA);
        rd(RA, 8'h09, 1'b1, "R9 zero clears only bit1");
        cyc(4'b0000, 1'b1, 8'h00, 12'h02C);
        rd(RA, 8'h09, 1'b1, "R9 write at other address ignored");
        rd(12'h02C, 8'h00, 1'b1, "R3 other address reads zero");
        rd(12'h000, 8'h00, 1'b1, "R3 address zero reads zero");
        cyc(4'b0000, 1'b1, 8'hF6, RA);
        rd(RA, 8'h00, 1'b0, "R8 zero-write clears bit0, R9 reserved data ignored");
    endtask

    task automatic t_collide;
        cyc(4'b1000, 1'b1, 8'h00, RA);
        rd(RA, 8'h08, 1'b1, "R10 watchdog set beats zero-write");
        cyc(4'b0001, 1'b1, 8'h00, RA);
        rd(RA, 8'h01, 1'b1, "R10 power-on set beats zero-write");
        cyc(4'b0101, 1'b0, 8'h00, RA);
        rd(RA, 8'h03, 1'b1, "R10 external set beats power-on clear");
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {ev_wdt, ev_ext, ev_bod, ev_por} = 4'b0;
        bus_addr = RA; bus_we = 1'b0; bus_wdata = 8'h00;
        t_reset();
        t_wdt();
        t_ext_bod();
        t_cumulative_por();
        t_writes();
        t_collide();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule